// File: doc/BRIEF.md
# Serial Channel Mode Register and Clock/Trigger Front End

This block sits at the front of one channel of a multi-mode serial interface. It holds the channel's 16-bit mode word, written and read over a plain register bus. The mode word picks which of two prescaler enables acts as the channel's operation tick. It picks where the transfer tick comes from: an internal divider run from the operation tick, or a synchronized external serial clock pin. It also picks the start condition for a transfer.

Software arms a transfer with a one-cycle start strobe. With the software trigger selected, the block issues a one-cycle transfer-start pulse on the next operation tick. With the edge trigger selected, the pulse waits for a falling edge on the receive-data pin that arrives after the strobe. The mode word also supplies the protocol field and the interrupt-source bit to the downstream engines. It also supplies a receive-polarity control, which acts only in UART mode.

All logic runs on one system clock. The prescaler outputs and the external pin are treated as enables and levels. None of them is used as a clock.

Top module: `sch_mode_front`

## Requirements
- R1: After reset, rd_data reads 0x0020, and xfer_tick, xfer_start, start_pend, op_mode and irq_sel are all 0.
- R2: Whatever value is written, bits 13..9, 7, 4 and 3 of rd_data read 0 and bit 5 reads 1. A write of 0xFFFF with the channel disabled reads back 0xC167.
- R3: While chan_en is 1, a write changes only bit 0 of the mode word. Bits 15..1 keep their values.
- R4: op_tick follows pre_tick0 when mode bit 15 is 0, and follows pre_tick1 when mode bit 15 is 1.
- R5: When mode bit 14 is 0 and chan_en is 1, xfer_tick is a one-cycle pulse once every 2*(div_val+1) operation ticks. The first pulse comes on the 2*(div_val+1)-th operation tick after enable. The count is held clear while the channel is disabled.
- R6: When mode bit 14 is 1, each rising edge of sck_in gives exactly one xfer_tick pulse. The pulse comes three operation ticks after the pin changes. Falling edges and the divider give no pulses.
- R7: Mode bits 2..1 drive op_mode, coded 00 = CSI, 01 = UART, 10 = I2C. Bit 0 drives irq_sel. rx_level is the synchronized rxd_in, inverted when bit 6 is 1 and op_mode is 01; otherwise it is not inverted.
- R8: When mode bit 8 is 0, a start strobe with the channel enabled sets start_pend on the next edge. xfer_start then pulses for one cycle on the following operation tick, and start_pend clears.
- R9: When mode bit 8 is 1, xfer_start pulses only on a falling edge of rxd_in that comes after the strobe. The pulse comes three operation ticks after the pin falls. A fall that comes before the strobe does not start a transfer.
- R10: Dropping chan_en clears start_pend. A start strobe with the channel disabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 16 | Mode word write value |
| rd_data | output | 16 | Mode word read value |
| chan_en | input | 1 | Channel-enable status |
| start_strobe | input | 1 | Software start request, one cycle |
| pre_tick0 | input | 1 | Prescaler enable, choice 0 |
| pre_tick1 | input | 1 | Prescaler enable, choice 1 |
| div_val | input | 7 | Divide value N from the data register |
| sck_in | input | 1 | External serial clock pin |
| rxd_in | input | 1 | Receive-data pin |
| op_tick | output | 1 | Selected operation tick |
| xfer_tick | output | 1 | Transfer tick enable |
| xfer_start | output | 1 | One-cycle transfer-start pulse |
| start_pend | output | 1 | Start armed and waiting for its condition |
| op_mode | output | 2 | Protocol select field |
| irq_sel | output | 1 | Interrupt-source select bit |
| rx_level | output | 1 | Synchronized, polarity-adjusted receive data |

## Verification
Mode word writes appear on rd_data one edge after the write. op_tick and the protocol outputs are combinational and are sampled one time unit after the inputs change. With the operation tick held high, the soft trigger sets start_pend one edge after the strobe, and xfer_start pulses one edge after that. A pin edge on sck_in or rxd_in needs two synchronizer stages and then the output register, so its pulse is checked absent after two edges and present after the third. Divider periods are measured as edge counts from enable to the first pulse and then between pulses. All sampling happens one time unit after each rising edge, where inputs are also driven.

// File: rtl/sch_pkg.sv
`timescale 1ns/1ps
package sch_pkg;
   localparam int MODE_W = 16;
   localparam logic [MODE_W-1:0] MODE_RST   = 16'h0020;
   localparam logic [MODE_W-1:0] MODE_WMASK = 16'hC147;
   localparam logic [MODE_W-1:0] MODE_ONES  = 16'h0020;
   localparam int B_OPCLK = 15;
   localparam int B_TCLK  = 14;
   localparam int B_TRIG  = 8;
   localparam int B_RXINV = 6;
   localparam int B_IRQ   = 0;
   typedef enum logic [1:0] {
      OPM_CSI  = 2'b00,
      OPM_UART = 2'b01,
      OPM_I2C  = 2'b10,
      OPM_RSVD = 2'b11
   } opmode_e;
endpackage

// File: rtl/sch_sync.sv
`timescale 1ns/1ps
module sch_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic lvl_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sch_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  chain <= {STAGES{RST_LVL}};
      else if (en) chain <= {chain[STAGES-2:0], din};
   end

   assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/sch_mode_reg.sv
`timescale 1ns/1ps
module sch_mode_reg
   import sch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              chan_en,
   output logic [MODE_W-1:0] mode_q
);
   logic [MODE_W-1:0] next_open;
   logic [MODE_W-1:0] next_locked;

   assign next_open   = (wr_data & MODE_WMASK) | MODE_ONES;
   assign next_locked = {mode_q[MODE_W-1:1], wr_data[B_IRQ]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= MODE_RST;
      else if (wr_en) mode_q <= chan_en ? next_locked : next_open;
   end
endmodule

// File: rtl/sch_tclk_gen.sv
`timescale 1ns/1ps
module sch_tclk_gen #(
   parameter int DIV_W      = 7,
   parameter int SYNC_N     = 2,
   parameter bit EXT_SCK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             op_tick,
   input  logic             ext_sel,
   input  logic [DIV_W-1:0] div_val,
   input  logic             sck_in,
   output logic             xfer_tick
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;
   logic          ext_edge;

   assign limit = {div_val, 1'b1};

   if (EXT_SCK_EN) begin : g_ext
      logic sck_lvl;
      logic sck_prev;
      sch_sync #(.STAGES(SYNC_N), .RST_LVL(1'b0)) u_sck_sync (
         .clk(clk), .rst_n(rst_n), .en(op_tick), .din(sck_in), .lvl_o(sck_lvl)
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sck_prev <= 1'b0;
         else if (op_tick) sck_prev <= sck_lvl;
      end
      assign ext_edge = sck_lvl & ~sck_prev;
   end else begin : g_noext
      assign ext_edge = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         xfer_tick <= 1'b0;
      end else begin
         xfer_tick <= 1'b0;
         if (!run || ext_sel) begin
            cnt <= '0;
         end else if (op_tick) begin
            if (cnt == limit) begin
               cnt       <= '0;
               xfer_tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (run && ext_sel && op_tick && ext_edge) xfer_tick <= 1'b1;
      end
   end
endmodule

// File: rtl/sch_start_arm.sv
`timescale 1ns/1ps
module sch_start_arm #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic op_tick,
   input  logic edge_sel,
   input  logic start_strobe,
   input  logic rxd_in,
   output logic rxd_lvl,
   output logic start_pend,
   output logic xfer_start
);
   logic rxd_prev;
   logic rxd_fall;
   logic fire;

   sch_sync #(.STAGES(SYNC_N), .RST_LVL(1'b1)) u_rxd_sync (
      .clk(clk), .rst_n(rst_n), .en(op_tick), .din(rxd_in), .lvl_o(rxd_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rxd_prev <= 1'b1;
      else if (op_tick) rxd_prev <= rxd_lvl;
   end

   assign rxd_fall = rxd_prev & ~rxd_lvl;
   assign fire     = run & start_pend & op_tick & (~edge_sel | rxd_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pend <= 1'b0;
         xfer_start <= 1'b0;
      end else begin
         xfer_start <= fire;
         if (!run)              start_pend <= 1'b0;
         else if (fire)         start_pend <= 1'b0;
         else if (start_strobe) start_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/sch_mode_front.sv
`timescale 1ns/1ps
module sch_mode_front
   import sch_pkg::*;
#(
   parameter int DIV_W      = 7,
   parameter int SYNC_N     = 2,
   parameter bit EXT_SCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output logic [MODE_W-1:0] rd_data,
   input  logic              chan_en,
   input  logic              start_strobe,
   input  logic              pre_tick0,
   input  logic              pre_tick1,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              sck_in,
   input  logic              rxd_in,
   output logic              op_tick,
   output logic              xfer_tick,
   output logic              xfer_start,
   output logic              start_pend,
   output logic [1:0]        op_mode,
   output logic              irq_sel,
   output logic              rx_level
);
   if (DIV_W < 1 || DIV_W > 15) begin : g_bad_div
      $error("sch_mode_front: DIV_W out of range 1..15");
   end

   logic [MODE_W-1:0] mode_q;
   logic              rxd_lvl;
   logic              rx_invert;

   sch_mode_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .chan_en(chan_en), .mode_q(mode_q)
   );

   assign rd_data   = mode_q;
   assign op_tick   = mode_q[B_OPCLK] ? pre_tick1 : pre_tick0;
   assign op_mode   = mode_q[2:1];
   assign irq_sel   = mode_q[B_IRQ];
   assign rx_invert = mode_q[B_RXINV] & (mode_q[2:1] == OPM_UART);
   assign rx_level  = rxd_lvl ^ rx_invert;

   sch_tclk_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N), .EXT_SCK_EN(EXT_SCK_EN)) u_tclk (
      .clk(clk), .rst_n(rst_n), .run(chan_en), .op_tick(op_tick),
      .ext_sel(mode_q[B_TCLK]), .div_val(div_val), .sck_in(sck_in),
      .xfer_tick(xfer_tick)
   );

   sch_start_arm #(.SYNC_N(SYNC_N)) u_start (
      .clk(clk), .rst_n(rst_n), .run(chan_en), .op_tick(op_tick),
      .edge_sel(mode_q[B_TRIG]), .start_strobe(start_strobe), .rxd_in(rxd_in),
      .rxd_lvl(rxd_lvl), .start_pend(start_pend), .xfer_start(xfer_start)
   );
endmodule

// File: rtl/sch_mode_front_chk.sv
`timescale 1ns/1ps
module sch_mode_front_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        chan_en,
   input logic [15:0] rd_data,
   input logic        xfer_tick,
   input logic        xfer_start,
   input logic        start_pend
);
   assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5] && ((rd_data & 16'h3E98) == 16'h0000));

   assert_locked_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> (rd_data[15:1] == $past(rd_data[15:1])));

   assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_tick |=> !xfer_tick);

   assert_start_from_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> ($past(start_pend) && !start_pend));

   assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (!start_pend && !xfer_start && !xfer_tick));
endmodule

bind sch_mode_front sch_mode_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rd_data(rd_data),
   .xfer_tick(xfer_tick), .xfer_start(xfer_start), .start_pend(start_pend)
);

// File: tb/sch_mode_front_test.sv
`timescale 1ns/1ps
module sch_mode_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        chan_en = 1'b0;
   logic        start_strobe = 1'b0;
   logic        pre_tick0 = 1'b1;
   logic        pre_tick1 = 1'b0;
   logic [6:0]  div_val = '0;
   logic        sck_in = 1'b0;
   logic        rxd_in = 1'b1;
   logic        op_tick, xfer_tick, xfer_start, start_pend, irq_sel, rx_level;
   logic [1:0]  op_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // {divide value, expected period in edges}
   localparam logic [15:0] DIV_TAB [4] = '{
      {7'd0, 9'd2}, {7'd3, 9'd8}, {7'd10, 9'd22}, {7'd127, 9'd256}
   };

   always #2.5 clk = ~clk;

   sch_mode_front uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .chan_en(chan_en), .start_strobe(start_strobe), .pre_tick0(pre_tick0),
      .pre_tick1(pre_tick1), .div_val(div_val), .sck_in(sck_in), .rxd_in(rxd_in),
      .op_tick(op_tick), .xfer_tick(xfer_tick), .xfer_start(xfer_start),
      .start_pend(start_pend), .op_mode(op_mode), .irq_sel(irq_sel), .rx_level(rx_level)
   );

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic count_ticks(input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         step();
         if (xfer_tick) c++;
      end
   endtask

   task automatic count_starts(input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         step();
         if (xfer_start) c++;
      end
   endtask

   initial begin
      int c, first, gap;
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 rd_data", rd_data, 32'h0020);
      chk("R1 outputs", {xfer_tick, xfer_start, start_pend, op_mode, irq_sel}, 0);

      // R5 divider periods, table-driven
      for (int i = 0; i < 4; i++) begin
         chan_en = 1'b0;
         wr(16'h0000);
         div_val = DIV_TAB[i][15:9];
         step();
         chan_en = 1'b1;
         first = 0;
         do begin step(); first++; end while (!xfer_tick && first < 600);
         chk("R5 first pulse", first, DIV_TAB[i][8:0]);
         gap = 0;
         do begin step(); gap++; end while (!xfer_tick && gap < 600);
         chk("R5 period", gap, DIV_TAB[i][8:0]);
      end
      chan_en = 1'b0;
      div_val = 7'd0;
      step();

      // R2 fixed bits
      wr(16'hFFFF);
      chk("R2 all ones", rd_data, 32'hC167);
      wr(16'h0000);
      chk("R2 all zeros", rd_data, 32'h0020);

      // R3 lock while enabled
      chan_en = 1'b1;
      wr(16'hFFFF);
      chk("R3 locked write", rd_data, 32'h0021);
      wr(16'h0000);
      chk("R3 bit0 clear", rd_data, 32'h0020);
      chan_en = 1'b0;
      step();

      // R4 operation clock choice
      pre_tick0 = 1'b0; pre_tick1 = 1'b1; #1;
      chk("R4 sel0 low", op_tick, 0);
      pre_tick0 = 1'b1; pre_tick1 = 1'b0; #1;
      chk("R4 sel0 high", op_tick, 1);
      wr(16'h8000);
      chk("R4 sel1 low", op_tick, 0);
      pre_tick1 = 1'b1; #1;
      chk("R4 sel1 high", op_tick, 1);
      wr(16'h0000);
      pre_tick1 = 1'b0;

      // R7 protocol field, irq bit, receive polarity
      wr(16'h0002);
      chk("R7 UART code", op_mode, 2'b01);
      wr(16'h0004);
      chk("R7 I2C code", op_mode, 2'b10);
      wr(16'h0042);
      chk("R7 UART inverted rx", rx_level, 0);
      wr(16'h0044);
      chk("R7 I2C no invert", rx_level, 1);
      wr(16'h0001);
      chk("R7 irq_sel", irq_sel, 1);
      wr(16'h0000);

      // R6 external serial clock
      wr(16'h4000);
      chan_en = 1'b1;
      count_ticks(20, c);
      chk("R6 no divider ticks", c, 0);
      sck_in = 1'b1;
      step(2);
      chk("R6 not yet", xfer_tick, 0);
      step();
      chk("R6 pulse due", xfer_tick, 1);
      count_ticks(10, c);
      chk("R6 single pulse", c, 0);
      sck_in = 1'b0;
      count_ticks(10, c);
      chk("R6 falling ignored", c, 0);
      chan_en = 1'b0;
      step();

      // R8 software trigger
      wr(16'h0000);
      chan_en = 1'b1;
      step();
      start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      chk("R8 pend set", {start_pend, xfer_start}, 2'b10);
      step();
      chk("R8 start pulse", {start_pend, xfer_start}, 2'b01);
      step();
      chk("R8 pulse ends", xfer_start, 0);
      chan_en = 1'b0;
      step();

      // R9 edge trigger
      wr(16'h0100);
      chan_en = 1'b1;
      rxd_in = 1'b0;
      step(6);
      start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      count_starts(6, c);
      chk("R9 early fall ignored", c, 0);
      chk("R9 still pending", start_pend, 1);
      rxd_in = 1'b1;
      count_starts(6, c);
      chk("R9 rise ignored", c, 0);
      rxd_in = 1'b0;
      step(2);
      chk("R9 not yet", xfer_start, 0);
      step();
      chk("R9 start on fall", {start_pend, xfer_start}, 2'b01);
      rxd_in = 1'b1;
      step(6);

      // R10 disable clears pending, strobe ignored when disabled
      start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      chk("R10 armed", start_pend, 1);
      chan_en = 1'b0;
      step();
      chk("R10 cleared", start_pend, 0);
      start_strobe = 1'b1;
      step();
      start_strobe = 1'b0;
      chk("R10 strobe while off", start_pend, 0);
      chan_en = 1'b1;
      rxd_in = 1'b0;
      count_starts(8, c);
      chk("R10 no start after clear", c, 0);
      chan_en = 1'b0;
      rxd_in = 1'b1;
      step(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule